// File: doc/BRIEF.md
# Error-Corrected Page Flash Controller

This block sits between a simple host command port and a behavioural flash array in which every stored data word carries sideband check bits. The host asks for one of four operations: read one word, erase one page, program one whole page, or blank-check one page. Each program computes a single-error-correcting, double-error-detecting code for every word and stores it with the data. Each read recombines data and check bits. It returns corrected data and raises a corrected flag when one stored bit is wrong, and it raises an uncorrectable flag when two bits are wrong.

At the host level a word that has been erased and not yet programmed reads back as all zeros, with the uncorrectable flag set. Programming turns host-visible bits from 0 to 1. Each word may be programmed only once between erases. Within a page program, a word whose data is all zeros is skipped and stays erased, so a page can be filled one word per program operation. A non-zero word aimed at an already programmed location is refused and reported. Blank check inspects the raw cells and does not go through the error decoder.

Page program data flows in on a valid/ready stream. A beat transfers on a clock edge where `wdata_valid` and `wdata_ready` are both high. The host may hold `wdata_valid` low for any number of cycles and the controller waits. The controller raises `wdata_ready` only while it is collecting a page. The data must stay stable while `wdata_valid` is high and `wdata_ready` is low. Commands use the same rule on `cmd_valid`/`cmd_ready`. The read response has no back-pressure: it appears exactly one cycle after acceptance.

Top module: `eccf_ctrl`

## Requirements
- R1: An erase command whose byte address has all page-offset bits zero erases every word of that page. Afterwards a read of any of those words returns data 0 with `rd_uncorr`=1 and `rd_corr`=0, and the words may be programmed again.
- R2: A program command with a page-aligned address takes exactly PAGE_BYTES/4 data beats, which are written to word offsets 0,1,2,... in order. Reading back a programmed word returns its exact data with both flags 0.
- R3: A beat whose data is all zeros leaves its word untouched. An erased word stays erased (it reads 0 with `rd_uncorr`=1), and a later program operation can still write it.
- R4: A non-zero beat aimed at an already programmed word is refused. The stored word keeps its old value, `op_err` is 1 during the `done` pulse, and the other beats of the same operation are still written.
- R5: A programmed word with any one of its 39 stored bits flipped reads back with its original data and `rd_corr`=1, `rd_uncorr`=0.
- R6: A programmed word with two stored bits flipped reads back with `rd_uncorr`=1 and `rd_corr`=0. The two flags are never high together.
- R7: A blank check reports `blank_ok`=1 during `done` only when every raw cell of the page is in the erased state. Reset and erase leave a page blank. A programmed non-zero word, or any single flipped raw bit in the page, makes it report 0.
- R8: An erase, program or blank-check command whose address has non-zero page-offset bits does nothing. It finishes with `done` and `op_err`=1, and a misaligned program never raises `wdata_ready`.
- R9: `rd_valid` is high in exactly the cycle after a read command (`cmd_op`=2'b00) is accepted. The two low address bits are ignored on reads.
- R10: Command codes are 2'b00 read, 2'b01 erase, 2'b10 program, 2'b11 blank check. `cmd_ready` is low and `busy` high from the acceptance of an erase, program or blank check until its `done`, which is a one-cycle pulse. Gaps in `wdata_valid` stall the program operation without losing beats.
- R11: After reset `cmd_ready`=1, `busy`=0, `done`=0 and `rd_valid`=0, and every page is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 00 read, 01 erase, 10 program, 11 blank check |
| cmd_addr | input | clog2(NUM_PAGES*PAGE_BYTES) | Byte address |
| wdata_valid | input | 1 | Program data beat valid |
| wdata_ready | output | 1 | Controller takes program data |
| wdata | input | DATA_W | Program data, host-level bit values |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read data (0 for erased or uncorrectable) |
| rd_corr | output | 1 | One bit was corrected |
| rd_uncorr | output | 1 | Word erased or not correctable |
| busy | output | 1 | Erase, program or blank check in progress |
| done | output | 1 | One-cycle end of erase, program or blank check |
| op_err | output | 1 | Valid with done: operation refused in whole or part |
| blank_ok | output | 1 | Valid with done: page found blank |
| flip_en | input | 1 | Invert one stored bit of the behavioural array |
| flip_word | input | clog2(NUM_PAGES*PAGE_BYTES/4) | Word index for flip |
| flip_bit | input | clog2(DATA_W+chk+1) | Stored bit index for flip |

## Verification
The bench builds the controller with 32-bit words, 32-byte pages (eight words) and four pages. A full page program, a page-wide blank check and reprogramming rules across every offset of a page then take only a few dozen cycles. Misaligned addresses, neighbouring pages and the last word of a page are all reachable with short directed sequences. The flip port reaches single and double stored-bit errors on chosen words, including the overall parity bit and the top bit of the codeword.

// File: rtl/eccf_pkg.sv
package eccf_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_ERASE = 2'b01,
    OP_PROG  = 2'b10,
    OP_BLANK = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_BLANK,
    ST_FIN
  } st_e;

  // Number of Hamming check bits (without overall parity) for a data width
  function automatic int chk_bits(input int dw);
    int p;
    p = 0;
    for (int i = 0; i < 16; i++) begin
      if ((1 << p) < dw + p + 1) p++;
    end
    return p;
  endfunction

endpackage

// File: rtl/eccf_enc.sv
module eccf_enc #(
  parameter int DATA_W = 32,
  parameter int CHK    = 6,
  parameter int CW_W   = DATA_W + CHK + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   cw
);

  logic [CW_W-1:0] c;

  always_comb begin
    int  k;
    logic par;
    c = '0;
    k = 0;
    // data bits go to positions that are not powers of two
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = data[k];
        k++;
      end
    end
    for (int i = 0; i < CHK; i++) begin
      par = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> i) & 1) == 1) par = par ^ c[p];
      end
      c[1 << i] = par;
    end
    c[0] = ^c[CW_W-1:1];
  end

  assign cw = c;

endmodule

// File: rtl/eccf_dec.sv
module eccf_dec #(
  parameter int DATA_W = 32,
  parameter int CHK    = 6,
  parameter int CW_W   = DATA_W + CHK + 1
) (
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              corr,
  output logic              uncorr
);

  logic [CHK-1:0]  syn;
  logic            odd;
  logic [CW_W-1:0] fixed;

  always_comb begin
    for (int i = 0; i < CHK; i++) begin
      syn[i] = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> i) & 1) == 1) syn[i] = syn[i] ^ cw[p];
      end
    end
    odd = ^cw;
  end

  always_comb begin
    int k;
    fixed  = cw;
    corr   = 1'b0;
    uncorr = 1'b0;
    if (odd) begin
      if (syn == '0) begin
        fixed[0] = ~cw[0];
        corr     = 1'b1;
      end else if (int'(syn) < CW_W) begin
        for (int p = 1; p < CW_W; p++) begin
          if (int'(syn) == p) fixed[p] = ~cw[p];
        end
        corr = 1'b1;
      end else begin
        uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      uncorr = 1'b1;
    end
    data = '0;
    k    = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        data[k] = fixed[p];
        k++;
      end
    end
  end

  always_comb begin
    a_flags_excl_r6 : assert (!(corr && uncorr));
  end

endmodule

// File: rtl/eccf_array.sv
module eccf_array #(
  parameter int WA_W = 5,
  parameter int WOFF = 3,
  parameter int CW_W = 39,
  parameter int FB_W = 6,
  localparam int PG_W  = WA_W - WOFF,
  localparam int DEPTH = 1 << WA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WA_W-1:0] a_addr,
  output logic [CW_W-1:0] a_raw,
  output logic            a_prog,
  input  logic [WA_W-1:0] b_addr,
  output logic [CW_W-1:0] b_raw,
  output logic            b_prog,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [CW_W-1:0] wr_raw,
  input  logic            er_en,
  input  logic [PG_W-1:0] er_page,
  input  logic            fl_en,
  input  logic [WA_W-1:0] fl_addr,
  input  logic [FB_W-1:0] fl_bit
);

  // raw cells: all ones is the erased state
  logic [CW_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] prog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      prog_q <= '0;
    end else begin
      if (er_en) begin
        for (int w = 0; w < (1 << WOFF); w++) begin
          mem[{er_page, WOFF'(w)}]    <= '1;
          prog_q[{er_page, WOFF'(w)}] <= 1'b0;
        end
      end
      if (wr_en) begin
        mem[wr_addr]    <= wr_raw;
        prog_q[wr_addr] <= 1'b1;
      end
      if (fl_en && int'(fl_bit) < CW_W) begin
        mem[fl_addr][fl_bit] <= ~mem[fl_addr][fl_bit];
      end
    end
  end

  assign a_raw  = mem[a_addr];
  assign a_prog = prog_q[a_addr];
  assign b_raw  = mem[b_addr];
  assign b_prog = prog_q[b_addr];

  p_write_once_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !prog_q[wr_addr]);

  p_wr_not_blank_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(&wr_raw));

  p_erase_clears_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    er_en |=> !prog_q[{$past(er_page), {WOFF{1'b0}}}]);

endmodule

// File: rtl/eccf_ctrl.sv
module eccf_ctrl
  import eccf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_BYTES = 512,
  parameter int NUM_PAGES  = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cmd_valid,
  output logic                                          cmd_ready,
  input  logic [1:0]                                    cmd_op,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]       cmd_addr,
  input  logic                                          wdata_valid,
  output logic                                          wdata_ready,
  input  logic [DATA_W-1:0]                             wdata,
  output logic                                          rd_valid,
  output logic [DATA_W-1:0]                             rd_data,
  output logic                                          rd_corr,
  output logic                                          rd_uncorr,
  output logic                                          busy,
  output logic                                          done,
  output logic                                          op_err,
  output logic                                          blank_ok,
  input  logic                                          flip_en,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES/(DATA_W/8))-1:0] flip_word,
  input  logic [$clog2(DATA_W+chk_bits(DATA_W)+1)-1:0]  flip_bit
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BOFF       = $clog2(WORD_BYTES);
  localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES;
  localparam int WOFF       = $clog2(PAGE_WORDS);
  localparam int PG_W       = $clog2(NUM_PAGES);
  localparam int WA_W       = PG_W + WOFF;
  localparam int ADDR_W     = WA_W + BOFF;
  localparam int PG_LSB     = WOFF + BOFF;
  localparam int CHK        = chk_bits(DATA_W);
  localparam int CW_W       = DATA_W + CHK + 1;
  localparam int FB_W       = $clog2(CW_W);

  st_e              st_q;
  logic [WOFF-1:0]  cnt_q;
  logic [PG_W-1:0]  page_q;
  logic             err_q;
  logic             blank_q;
  logic             rd_v_q;
  logic [WA_W-1:0]  rd_addr_q;

  logic             acc;
  logic             aligned;
  op_e              op;
  logic             beat;
  logic             last;

  logic [CW_W-1:0]  a_raw, b_raw, enc_cw;
  logic             a_prog, b_prog;
  logic [DATA_W-1:0] dec_data;
  logic             dec_corr, dec_unc;
  logic             wr_en, er_en;
  logic [WA_W-1:0]  b_addr;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (st_q == ST_IDLE);
  assign acc       = cmd_valid && cmd_ready;
  assign aligned   = (cmd_addr[PG_LSB-1:0] == '0);
  assign wdata_ready = (st_q == ST_PROG);
  assign beat      = wdata_valid && wdata_ready;
  assign last      = (cnt_q == WOFF'(PAGE_WORDS - 1));
  assign b_addr    = {page_q, cnt_q};

  // a beat of zeros leaves the word alone; a second write is refused
  assign wr_en = beat && (|wdata) && !b_prog;
  assign er_en = acc && (op == OP_ERASE) && aligned;

  eccf_enc #(.DATA_W(DATA_W), .CHK(CHK), .CW_W(CW_W)) enc_i (
    .data (wdata),
    .cw   (enc_cw)
  );

  eccf_dec #(.DATA_W(DATA_W), .CHK(CHK), .CW_W(CW_W)) dec_i (
    .cw     (~a_raw),
    .data   (dec_data),
    .corr   (dec_corr),
    .uncorr (dec_unc)
  );

  eccf_array #(.WA_W(WA_W), .WOFF(WOFF), .CW_W(CW_W), .FB_W(FB_W)) arr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_addr  (rd_addr_q),
    .a_raw   (a_raw),
    .a_prog  (a_prog),
    .b_addr  (b_addr),
    .b_raw   (b_raw),
    .b_prog  (b_prog),
    .wr_en   (wr_en),
    .wr_addr (b_addr),
    .wr_raw  (~enc_cw),
    .er_en   (er_en),
    .er_page (cmd_addr[ADDR_W-1:PG_LSB]),
    .fl_en   (flip_en),
    .fl_addr (flip_word),
    .fl_bit  (flip_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      page_q    <= '0;
      err_q     <= 1'b0;
      blank_q   <= 1'b0;
      rd_v_q    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_v_q <= acc && (op == OP_READ);
      unique case (st_q)
        ST_IDLE: begin
          if (acc) begin
            err_q   <= 1'b0;
            blank_q <= 1'b0;
            cnt_q   <= '0;
            page_q  <= cmd_addr[ADDR_W-1:PG_LSB];
            unique case (op)
              OP_READ:  rd_addr_q <= cmd_addr[ADDR_W-1:BOFF];
              OP_ERASE: begin
                st_q  <= ST_FIN;
                err_q <= !aligned;
              end
              OP_PROG: begin
                st_q  <= aligned ? ST_PROG : ST_FIN;
                err_q <= !aligned;
              end
              OP_BLANK: begin
                st_q    <= aligned ? ST_BLANK : ST_FIN;
                err_q   <= !aligned;
                blank_q <= aligned;
              end
              default: ;
            endcase
          end
        end
        ST_PROG: begin
          if (beat) begin
            if ((|wdata) && b_prog) err_q <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
            if (last) st_q <= ST_FIN;
          end
        end
        ST_BLANK: begin
          if (!(&b_raw)) blank_q <= 1'b0;
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign op_err   = done && err_q;
  assign blank_ok = done && blank_q;

  assign rd_valid  = rd_v_q;
  assign rd_data   = (a_prog && !dec_unc) ? dec_data : '0;
  assign rd_corr   = a_prog && dec_corr;
  assign rd_uncorr = !a_prog || dec_unc;

  p_done_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_flags_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !(rd_corr && rd_uncorr));

  p_no_beat_when_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !wr_en);

endmodule

// File: tb/eccf_ctrl_tb_top.sv
module eccf_ctrl_tb_top;

  localparam int DW = 32;
  localparam int PB = 32;
  localparam int NP = 4;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_op;
  logic [6:0]  cmd_addr;
  logic        wdata_valid, wdata_ready;
  logic [31:0] wdata;
  logic        rd_valid, rd_corr, rd_uncorr;
  logic [31:0] rd_data;
  logic        busy, done, op_err, blank_ok;
  logic        flip_en;
  logic [4:0]  flip_word;
  logic [5:0]  flip_bit;

  int n_cmp = 0;
  int n_bad = 0;

  eccf_ctrl #(.DATA_W(DW), .PAGE_BYTES(PB), .NUM_PAGES(NP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_corr(rd_corr), .rd_uncorr(rd_uncorr),
    .busy(busy), .done(done), .op_err(op_err), .blank_ok(blank_ok),
    .flip_en(flip_en), .flip_word(flip_word), .flip_bit(flip_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // each entry: data for one word of page 0; zero entries stay erased
  localparam logic [31:0] TBL [8] = '{
    32'h0101_0101, 32'hDEAD_BEEF, 32'h0000_0000, 32'h8000_0001,
    32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'h0000_0001
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int w, input logic [1:0] lo, output logic [31:0] d,
                    output logic c, output logic u, output logic v);
    issue(2'b00, 7'(w * 4) | {5'd0, lo});
    v = rd_valid; d = rd_data; c = rd_corr; u = rd_uncorr;
  endtask

  task automatic finish_op(output logic e, output logic b);
    while (!done) @(negedge clk);
    e = op_err; b = blank_ok;
    @(negedge clk);
    chk(!done, "R10 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic prog_page(input int pg, input logic [31:0] d [8], input bit gaps,
                           output logic e);
    logic b;
    issue(2'b10, 7'(pg * PB));
    for (int i = 0; i < 8; i++) begin
      if (gaps && (i % 2 == 1)) begin
        wdata_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
      wdata_valid = 1'b1; wdata = d[i];
      while (!wdata_ready) @(negedge clk);
      if (i == 3) chk(!cmd_ready && busy, "R10 busy during program",
                      {30'd0, cmd_ready, busy}, 32'd1);
      @(posedge clk);
      @(negedge clk);
    end
    wdata_valid = 1'b0;
    finish_op(e, b);
  endtask

  task automatic blank(input int pg, output logic b);
    logic e;
    issue(2'b11, 7'(pg * PB));
    finish_op(e, b);
  endtask

  task automatic flip(input int w, input int bitn);
    @(negedge clk);
    flip_en = 1'b1; flip_word = 5'(w); flip_bit = 6'(bitn);
    @(negedge clk);
    flip_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic c, u, v, e, b;
    logic [31:0] pd [8];

    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0;
    wdata_valid = 1'b0; wdata = '0; flip_en = 1'b0; flip_word = '0; flip_bit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(cmd_ready && !busy && !done && !rd_valid, "R11 reset outputs",
        {28'd0, cmd_ready, busy, done, rd_valid}, 32'h8);

    blank(0, b);
    chk(b == 1'b1, "R11 R7 page blank after reset", 32'(b), 32'd1);
    rd(0, 2'b00, d, c, u, v);
    chk(v && d == 0 && u && !c, "R1 erased word reads zero+uncorr", d, 32'd0);

    // R2 R3 R10: table program with stalls, then walk the table
    prog_page(0, TBL, 1'b1, e);
    chk(e == 1'b0, "R2 program status", 32'(e), 32'd0);
    for (int w = 0; w < 8; w++) begin
      rd(w, 2'b00, d, c, u, v);
      chk(v && d == TBL[w] && !c && (u == (TBL[w] == 0)),
          (TBL[w] == 0) ? "R3 zero beat left erased" : "R2 readback",
          d, TBL[w]);
    end
    @(negedge clk);
    chk(!rd_valid, "R9 rd_valid single cycle", 32'(rd_valid), 32'd0);

    blank(0, b);
    chk(b == 1'b0, "R7 programmed page not blank", 32'(b), 32'd0);

    // R3: append into the skipped word 2
    pd = '{default: 32'd0};
    pd[2] = 32'h0110_1001;
    prog_page(0, pd, 1'b0, e);
    chk(e == 1'b0, "R3 append status", 32'(e), 32'd0);
    rd(2, 2'b00, d, c, u, v);
    chk(d == 32'h0110_1001 && !u, "R3 appended word", d, 32'h0110_1001);

    // R4: overwrite word 0 refused, word 5 still written
    pd = '{default: 32'd0};
    pd[0] = 32'hF0F0_F0F0; pd[5] = 32'h0111_1000;
    prog_page(0, pd, 1'b0, e);
    chk(e == 1'b1, "R4 overwrite flagged", 32'(e), 32'd1);
    rd(0, 2'b00, d, c, u, v);
    chk(d == 32'h0101_0101 && !u && !c, "R4 word unchanged", d, 32'h0101_0101);
    rd(5, 2'b00, d, c, u, v);
    chk(d == 32'h0111_1000 && !u, "R4 other beat written", d, 32'h0111_1000);

    // R9: low address bits ignored
    rd(6, 2'b11, d, c, u, v);
    chk(v && d == 32'h1234_5678, "R9 low bits ignored", d, 32'h1234_5678);

    // R5: single flips
    flip(1, 0);
    rd(1, 2'b00, d, c, u, v);
    chk(d == 32'hDEAD_BEEF && c && !u, "R5 parity bit corrected", d, 32'hDEAD_BEEF);
    flip(4, 38);
    rd(4, 2'b00, d, c, u, v);
    chk(d == 32'hFFFF_FFFF && c && !u, "R5 top bit corrected", d, 32'hFFFF_FFFF);
    flip(3, 17);
    rd(3, 2'b00, d, c, u, v);
    chk(d == 32'h8000_0001 && c && !u, "R5 data bit corrected", d, 32'h8000_0001);
    // R6: double flip
    flip(6, 3);
    flip(6, 20);
    rd(6, 2'b00, d, c, u, v);
    chk(u && !c, "R6 double error flagged", {30'd0, c, u}, 32'd1);

    // R8: misaligned erase and program
    issue(2'b01, 7'd4);
    finish_op(e, b);
    chk(e == 1'b1, "R8 misaligned erase flagged", 32'(e), 32'd1);
    rd(0, 2'b00, d, c, u, v);
    chk(d == 32'h0101_0101, "R8 misaligned erase no effect", d, 32'h0101_0101);
    issue(2'b10, 7'd8);
    chk(!wdata_ready, "R8 misaligned program takes no data", 32'(wdata_ready), 32'd0);
    finish_op(e, b);
    chk(e == 1'b1, "R8 misaligned program flagged", 32'(e), 32'd1);

    // R1: erase page 0
    issue(2'b01, 7'd0);
    finish_op(e, b);
    chk(e == 1'b0, "R1 erase status", 32'(e), 32'd0);
    rd(1, 2'b00, d, c, u, v);
    chk(d == 0 && u && !c, "R1 erased after erase", d, 32'd0);
    blank(0, b);
    chk(b == 1'b1, "R7 blank after erase", 32'(b), 32'd1);
    pd = '{default: 32'd0};
    pd[0] = 32'hF0F0_F0F0; pd[7] = 32'h0000_0080;
    prog_page(0, pd, 1'b0, e);
    rd(0, 2'b00, d, c, u, v);
    chk(e == 1'b0 && d == 32'hF0F0_F0F0, "R1 reprogram after erase", d, 32'hF0F0_F0F0);
    rd(7, 2'b00, d, c, u, v);
    chk(d == 32'h0000_0080 && !u, "R2 last word of page", d, 32'h0000_0080);

    // R7: raw flip on an erased cell
    flip(8, 7);
    blank(1, b);
    chk(b == 1'b0, "R7 flipped erased cell seen", 32'(b), 32'd0);
    blank(2, b);
    chk(b == 1'b1, "R7 neighbour page blank", 32'(b), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule